// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 32K bytes with active-low chip select, output enable and write strobe. The host issues one byte-wide read or write at a time over a request/ready handshake. The controller turns each request into a timed sequence of memory control levels, holds the address and data steady for as long as the memory needs, and returns read data with a one-cycle valid strobe.

All memory timing minimums are given in nanoseconds, together with the clock period. The block rounds each one up to whole cycles, so one set of values serves any clock rate. Write strobes are always issued with the output enable released, so the memory never drives the bus during a write. The controller starts driving the shared data bus only after the memory outputs have had their float time. After reset, no request is taken until a power-up settling interval has passed.

Top module: `sram_ctl`

## Requirements
- R1: During reset and whenever `req_ready` is high, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0 and `rd_valid` is 0.
- R2: After reset is released, `req_ready` stays low for at least ceil(PWRUP_NS/CLK_PERIOD_NS) cycles and rises no later than two cycles after that. No memory cycle (`mem_ce_n` low) occurs before it rises.
- R3: A write holds `mem_ce_n` and `mem_we_n` low together for exactly WE_CYC cycles. WE_CYC is the largest of the rounded write-pulse, data-setup and address-to-write-end minimums. `mem_oe_n` stays 1, and the address and data stay constant through this window. The byte ends up stored at the requested address.
- R4: `mem_dq_oe` is 1 in every cycle of the write strobe and in the single cycle after `mem_we_n` returns high, and it is 0 at all other times.
- R5: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. When `mem_dq_oe` rises, `mem_oe_n` has already been 1 for at least ceil(T_HZOE_NS/CLK_PERIOD_NS) cycles.
- R6: A read holds `mem_ce_n` and `mem_oe_n` low and `mem_we_n` high, with a constant address, for exactly RD_CYC cycles. RD_CYC is the largest of the rounded address, chip-select and output-enable access times. The data bus is sampled at the edge that closes the last of these cycles.
- R7: `rd_valid` is high for exactly one cycle, RD_CYC cycles after the accepting edge. In that cycle `rd_data` carries the byte stored at the requested address.
- R8: `req_ready` is 0 from the accepting edge until the access and its recovery are complete. Two successive memory cycles start at least the rounded cycle-time minimum apart.
- R9: A request that is held valid while `req_ready` is low is taken exactly once, at the first edge where `req_ready` is high.
- R10: A write request never produces an `rd_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Byte to write |
| req_ready | output | 1 | Controller can accept a request this cycle |
| rd_data | output | DATA_W | Read result |
| rd_valid | output | 1 | One-cycle strobe marking `rd_data` valid |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dq_out | output | DATA_W | Byte driven onto the shared data bus |
| mem_dq_oe | output | 1 | Enables the bus driver for `mem_dq_out` |
| mem_dq_in | input | DATA_W | Byte read back from the shared data bus |

## Verification
The properties assume that the host changes its request inputs only between clock edges. They also assume the memory returns settled data once its access window has elapsed, so a sampled byte depends only on the address held during the strobe. The stimulus keeps to both. A behavioural memory in the bench updates its read bus at the falling clock edge, and only from the current control levels, and it returns a poison byte until the read strobe has lasted the required number of cycles. The host stimulus is driven only at falling edges and always waits for `req_ready`. One request is deliberately held through the whole power-up interval.

// File: rtl/sram_ctl_pkg.sv
// Shared types and cycle-rounding helpers for the SRAM access controller.
// Assumes every timing value is a non-negative integer number of ns.
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_BOOT,
        ST_IDLE,
        ST_WR,
        ST_WR_END,
        ST_RD,
        ST_GAP
    } seq_state_t;

    // Round a nanosecond minimum up to whole cycles, never below one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per_ns);
        int unsigned c;
        c = (ns + per_ns - 1) / per_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_pwrup.sv
// Power-up hold-off: counts PWR_CYC cycles after reset, then raises done.
// Assumes PWR_CYC >= 1. done stays high until the next reset.
module sram_ctl_pwrup #(
    parameter int unsigned PWR_CYC = 10000
) (
    input  logic clk,
    input  logic rst_n,
    output logic done
);
    localparam int unsigned CW = $clog2(PWR_CYC + 1);

    logic [CW-1:0] cnt;

    // Saturating count of cycles since reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt != CW'(PWR_CYC)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign done = (cnt == CW'(PWR_CYC));
endmodule

// File: rtl/sram_ctl_path.sv
// Datapath: latches address and write byte on accept, captures read byte.
// Assumes load and capture are never high in the same cycle.
module sram_ctl_path #(
    parameter int unsigned ADDR_W = 15,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] rd_data
);
    // Address and write data hold for the whole memory cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            dq_out   <= '0;
        end else if (load) begin
            mem_addr <= addr_in;
            dq_out   <= wdata_in;
        end
    end

    // Read byte captured at the end of the access window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (capture) begin
            rd_data <= dq_in;
        end
    end
endmodule

// File: rtl/sram_ctl_seq.sv
// Sequencer: one FSM times each write/read against cycle counts and
// produces registered, glitch-free memory control levels.
// Assumes WR_LAST >= WE_CYC and RD_LAST >= RD_CYC (derived by the top).
module sram_ctl_seq
    import sram_ctl_pkg::*;
#(
    parameter int unsigned WE_CYC  = 1,
    parameter int unsigned RD_CYC  = 1,
    parameter int unsigned WR_LAST = 1,
    parameter int unsigned RD_LAST = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_done,
    input  logic req_valid,
    input  logic req_write,
    output logic req_ready,
    output logic load,
    output logic capture,
    output logic rd_valid,
    output logic ce_n,
    output logic oe_n,
    output logic we_n,
    output logic dq_oe
);
    localparam int unsigned CNT_W = $clog2(umax(WR_LAST, RD_LAST) + 2);
    localparam logic [CNT_W-1:0] WE_END_K = CNT_W'(WE_CYC - 1);
    localparam logic [CNT_W-1:0] RD_END_K = CNT_W'(RD_CYC - 1);

    seq_state_t       st, st_nxt;
    logic [CNT_W-1:0] elapsed;
    logic [CNT_W-1:0] tgt;

    assign req_ready = (st == ST_IDLE);
    assign load      = req_ready && req_valid;

    // Next-state selection and read capture strobe.
    always_comb begin
        st_nxt  = st;
        capture = 1'b0;
        case (st)
            ST_BOOT:   if (pwr_done) st_nxt = ST_IDLE;
            ST_IDLE:   if (req_valid) st_nxt = req_write ? ST_WR : ST_RD;
            ST_WR:     if (elapsed == WE_END_K) st_nxt = ST_WR_END;
            ST_WR_END: st_nxt = (elapsed >= tgt) ? ST_IDLE : ST_GAP;
            ST_RD: begin
                if (elapsed == RD_END_K) begin
                    capture = 1'b1;
                    st_nxt  = ST_GAP;
                end
            end
            ST_GAP:    if (elapsed >= tgt) st_nxt = ST_IDLE;
            default:   st_nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_BOOT;
        else        st <= st_nxt;
    end

    // Cycle index within the current access; zero in the first cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed <= '0;
            tgt     <= '0;
        end else if (load) begin
            elapsed <= '0;
            tgt     <= req_write ? CNT_W'(WR_LAST) : CNT_W'(RD_LAST);
        end else if (elapsed != '1) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    // Memory control levels registered from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n  <= 1'b1;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            dq_oe <= 1'b0;
        end else begin
            ce_n  <= !(st_nxt inside {ST_WR, ST_WR_END, ST_RD});
            oe_n  <= (st_nxt != ST_RD);
            we_n  <= (st_nxt != ST_WR);
            dq_oe <= (st_nxt inside {ST_WR, ST_WR_END});
        end
    end

    // Read-valid strobe follows the capture edge by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= capture;
    end
endmodule

// File: rtl/sram_ctl.sv
// Top: asynchronous SRAM access controller. Converts ns minimums into
// cycle counts and wires hold-off, sequencer and datapath together.
// Assumes the host holds request inputs stable between clock edges.
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 15,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned PWRUP_NS      = 100000,
    parameter int unsigned T_WP_NS       = 7,
    parameter int unsigned T_DS_NS       = 5,
    parameter int unsigned T_AW_NS       = 7,
    parameter int unsigned T_WC_NS       = 10,
    parameter int unsigned T_RC_NS       = 10,
    parameter int unsigned T_AA_NS       = 10,
    parameter int unsigned T_ACE_NS      = 10,
    parameter int unsigned T_DOE_NS      = 5,
    parameter int unsigned T_HZOE_NS     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int unsigned C_WP   = ns_to_cyc(T_WP_NS, CLK_PERIOD_NS);
    localparam int unsigned C_DS   = ns_to_cyc(T_DS_NS, CLK_PERIOD_NS);
    localparam int unsigned C_AW   = ns_to_cyc(T_AW_NS, CLK_PERIOD_NS);
    localparam int unsigned C_WC   = ns_to_cyc(T_WC_NS, CLK_PERIOD_NS);
    localparam int unsigned C_RC   = ns_to_cyc(T_RC_NS, CLK_PERIOD_NS);
    localparam int unsigned C_AA   = ns_to_cyc(T_AA_NS, CLK_PERIOD_NS);
    localparam int unsigned C_ACE  = ns_to_cyc(T_ACE_NS, CLK_PERIOD_NS);
    localparam int unsigned C_DOE  = ns_to_cyc(T_DOE_NS, CLK_PERIOD_NS);
    localparam int unsigned C_HZOE = ns_to_cyc(T_HZOE_NS, CLK_PERIOD_NS);
    localparam int unsigned C_PWR  = ns_to_cyc(PWRUP_NS, CLK_PERIOD_NS);

    localparam int unsigned WE_CYC  = umax(umax(C_WP, C_DS), C_AW);
    localparam int unsigned RD_CYC  = umax(umax(C_AA, C_ACE), C_DOE);
    localparam int unsigned WR_LAST = umax(WE_CYC + 1, C_WC) - 1;
    localparam int unsigned RD_LAST = umax(RD_CYC + C_HZOE, C_RC) - 1;

    logic pwr_done;
    logic load;
    logic capture;

    sram_ctl_pwrup #(.PWR_CYC(C_PWR)) u_pwrup (
        .clk   (clk),
        .rst_n (rst_n),
        .done  (pwr_done)
    );

    sram_ctl_seq #(
        .WE_CYC  (WE_CYC),
        .RD_CYC  (RD_CYC),
        .WR_LAST (WR_LAST),
        .RD_LAST (RD_LAST)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_done  (pwr_done),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_ready (req_ready),
        .load      (load),
        .capture   (capture),
        .rd_valid  (rd_valid),
        .ce_n      (mem_ce_n),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n),
        .dq_oe     (mem_dq_oe)
    );

    sram_ctl_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .capture  (capture),
        .addr_in  (req_addr),
        .wdata_in (req_wdata),
        .dq_in    (mem_dq_in),
        .mem_addr (mem_addr),
        .dq_out   (mem_dq_out),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/sram_ctl_chk.sv
// Protocol checker for sram_ctl, attached by bind. Observes ports only.
// Assumes the same clock-period and power-up parameters as the top.
module sram_ctl_chk
    import sram_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 15,
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned PWRUP_NS      = 100000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_dq_oe
);
    localparam int unsigned PWR_CYC = ns_to_cyc(PWRUP_NS, CLK_PERIOD_NS);
    localparam int unsigned BW      = $clog2(PWR_CYC + 1);

    logic [BW-1:0] boot_cnt;

    // Independent count of cycles since reset release, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) boot_cnt <= '0;
        else if (boot_cnt != BW'(PWR_CYC)) boot_cnt <= boot_cnt + 1'b1;
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rd_valid));

    // R2
    boot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (boot_cnt == BW'(PWR_CYC)));

    // R3
    we_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> !mem_ce_n);

    // R3
    oe_off_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // R4
    drive_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);

    // R5
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R5
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> $past(mem_oe_n));

    // R6
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    // R7
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R8
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> !req_ready);
endmodule

bind sram_ctl sram_ctl_chk #(
    .ADDR_W        (ADDR_W),
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .PWRUP_NS      (PWRUP_NS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rd_valid  (rd_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_sram_ctl.sv
`timescale 1ns/1ps
module tb_sram_ctl;
    localparam int PER_NS = 5;
    localparam int PWR_NS = 1000;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + PER_NS - 1) / PER_NS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int B_NWE = mx(mx(cyc(7), cyc(5)), cyc(7));
    localparam int B_NRD = mx(mx(cyc(10), cyc(10)), cyc(5));
    localparam int B_HZ  = cyc(5);
    localparam int B_CYC = cyc(10);
    localparam int B_PWR = cyc(PWR_NS);

    logic        clk = 0;
    logic        rst_n = 0;
    logic        req_valid = 0;
    logic        req_write = 0;
    logic [14:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [14:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hC3;

    always #2.5 clk = ~clk;

    sram_ctl #(.CLK_PERIOD_NS(PER_NS), .PWRUP_NS(PWR_NS)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_data(rd_data), .rd_valid(rd_valid), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] init_byte(input logic [14:0] a);
        return a[7:0] ^ {a[14:8], 1'b1};
    endfunction

    logic [7:0] mdl    [32768];
    logic [7:0] shadow [32768];

    // Behavioural memory: samples control levels once per cycle at negedge.
    bit          boot_phase = 0, boot_touch = 0;
    bit          p_wr, p_rd, p_dqoe, p_ce_n;
    int          m_wlen, m_rrun, m_ohi, m_since, m_wcount = 0;
    logic [14:0] m_waddr, m_raddr;
    logic [7:0]  m_wdat;
    bit          wa, ra;

    always @(negedge clk) begin
        if (!rst_n) begin
            p_wr = 0; p_rd = 0; p_dqoe = 0; p_ce_n = 1;
            m_ohi = 100; m_since = 100; m_rrun = 0; m_wlen = 0;
            mem_dq_in = 8'hC3;
        end else begin
            wa = !mem_ce_n && !mem_we_n;
            ra = !mem_ce_n && !mem_oe_n && mem_we_n;
            if (boot_phase && !mem_ce_n) boot_touch = 1;
            if (wa) begin
                if (!p_wr) begin
                    m_wlen = 1; m_waddr = mem_addr; m_wdat = mem_dq_out;
                end else begin
                    m_wlen++;
                    if (mem_addr != m_waddr || mem_dq_out != m_wdat)
                        chk(0, "R3", "addr/data moved in strobe", int'(mem_addr), int'(m_waddr));
                end
                if (!mem_oe_n)  chk(0, "R3", "oe low during write", 0, 1);
                if (!mem_dq_oe) chk(0, "R4", "bus not driven in strobe", 0, 1);
            end else if (p_wr) begin
                chk(m_wlen == B_NWE, "R3", "write strobe length", m_wlen, B_NWE);
                chk(mem_dq_oe, "R4", "bus released before hold cycle", int'(mem_dq_oe), 1);
                mdl[m_waddr] = m_wdat;
                m_wcount++;
            end else if (mem_dq_oe) begin
                chk(0, "R4", "bus driven outside write", 1, 0);
            end
            if (mem_dq_oe && !mem_oe_n) chk(0, "R5", "bus contention", 1, 0);
            if (mem_dq_oe && !p_dqoe && m_ohi < B_HZ)
                chk(0, "R5", "turnaround too short", m_ohi, B_HZ);
            m_ohi = mem_oe_n ? ((m_ohi < 1000) ? m_ohi + 1 : m_ohi) : 0;
            if (m_since < 1000) m_since++;
            if (!mem_ce_n && p_ce_n) begin
                if (m_since < B_CYC) chk(0, "R8", "cycle start spacing", m_since, B_CYC);
                m_since = 0;
            end
            if (!ra && p_rd) chk(m_rrun == B_NRD, "R6", "read strobe length", m_rrun, B_NRD);
            if (ra) begin
                if (p_rd && mem_addr == m_raddr) m_rrun++;
                else begin m_rrun = 1; m_raddr = mem_addr; end
                mem_dq_in = (m_rrun >= B_NRD) ? mdl[mem_addr] : 8'h5A;
            end else begin
                m_rrun = 0;
                mem_dq_in = 8'hC3;
            end
            p_wr = wa; p_rd = ra; p_dqoe = mem_dq_oe; p_ce_n = mem_ce_n;
        end
    end

    // One host access; called and returns at a negedge with ready high.
    task automatic host_op(input bit wr, input logic [14:0] a, input logic [7:0] d);
        int n, seen, at;
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0;
        if (wr) shadow[a] = d;
        chk(req_ready == 0, "R8", "ready low after accept", int'(req_ready), 0);
        n = 0; seen = 0; at = -1;
        while (!req_ready && n < 50) begin
            if (rd_valid) begin
                seen++;
                if (at < 0) at = n;
                if (!wr) chk(rd_data == shadow[a], "R7", "read data", int'(rd_data), int'(shadow[a]));
            end
            @(negedge clk);
            n++;
        end
        if (rd_valid) seen++;
        if (wr) chk(seen == 0, "R10", "rd_valid on write", seen, 0);
        else begin
            chk(seen == 1, "R7", "rd_valid pulse count", seen, 1);
            chk(at == B_NRD, "R7", "rd_valid latency", at, B_NRD);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        int n, wc0;
        for (int i = 0; i < 32768; i++) begin
            mdl[i] = init_byte(15'(i));
            shadow[i] = init_byte(15'(i));
        end
        void'($urandom(32'd7411));
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(mem_ce_n && mem_oe_n && mem_we_n, "R1", "controls in reset", int'({mem_ce_n, mem_oe_n, mem_we_n}), 7);
        chk(!mem_dq_oe && !req_ready && !rd_valid, "R1", "bus/ready/valid in reset",
            int'({mem_dq_oe, req_ready, rd_valid}), 0);
        // R2/R9: request held through power-up
        boot_phase = 1;
        rst_n = 1;
        req_valid = 1; req_write = 1; req_addr = 15'd5; req_wdata = 8'h77;
        n = 0;
        wc0 = m_wcount;
        while (!req_ready && n < B_PWR + 20) begin
            @(negedge clk);
            n++;
        end
        boot_phase = 0;
        chk(n >= B_PWR && n <= B_PWR + 2, "R2", "power-up hold-off cycles", n, B_PWR);
        chk(!boot_touch, "R2", "memory touched during hold-off", int'(boot_touch), 0);
        @(negedge clk);
        req_valid = 0;
        shadow[5] = 8'h77;
        while (!req_ready) @(negedge clk);
        chk(m_wcount - wc0 == 1, "R9", "held request taken once", m_wcount - wc0, 1);
        // Directed corners
        host_op(0, 15'd5, 8'h00);
        host_op(1, 15'd0, 8'h00);
        host_op(1, 15'h7FFF, 8'hFF);
        host_op(1, 15'h2AAA, 8'hAA);
        host_op(0, 15'd0, 8'h00);
        host_op(0, 15'h7FFF, 8'h00);
        host_op(0, 15'h2AAA, 8'h00);
        host_op(0, 15'h1234, 8'h00);
        host_op(0, 15'h0001, 8'h00);
        host_op(1, 15'h0055, 8'h3C);
        host_op(0, 15'h0055, 8'h00);
        host_op(1, 15'h0055, 8'hC3);
        host_op(0, 15'h0055, 8'h00);
        // Random mix
        for (int k = 0; k < 400; k++) begin
            logic [14:0] a;
            a = ($urandom % 4 == 0) ? 15'($urandom) : 15'($urandom % 32);
            host_op(1'($urandom % 2), a, 8'($urandom));
            repeat ($urandom % 3) @(negedge clk);
        end
        repeat (5) @(negedge clk);
        // R1: idle levels after traffic
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready, "R1", "idle levels",
            int'({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}), 5'b11101);
        n = 0;
        for (int i = 0; i < 32768; i++) if (mdl[i] !== shadow[i]) n++;
        chk(n == 0, "R3", "stored contents mismatches", n, 0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule